// File: doc/BRIEF.md
# Mixed-width interval timer bank with timestamp counter

The block holds three down-counting interval timers and one 40-bit timestamp counter behind a small register bus. The first two interval timers are 16 bits wide and the third is 32 bits wide. Each interval timer counts down by one on every tick of the source it has selected. Two tick-enable inputs stand for the two reference clocks. When a count passes zero, the timer raises its own interrupt line. In periodic mode it then starts again from its load value. In free-running mode it wraps to all ones. The interrupt stays up until software writes any value to that timer's clear register.

The timestamp counter advances on every fast tick while its enable bit is set, and it never raises an interrupt. Software reads the lower 32 bits first. That read captures the upper eight bits, so the next read of the high word gives a value that matches the low word it just read.

The bus is a plain register port, not a stream. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`, with no wait states and no back-pressure. `bus_rd` only marks the cycle in which a read is consumed.

Top module: `timer_bank`

## Requirements
- R1: After reset, every readable register reads zero, all interrupt lines are low, and no timer or the timestamp counts.
- R2: Timer registers sit at fixed word offsets, and any other offset is unmapped:
  - Timer 1: load 0x00, value 0x04, control 0x08, clear 0x0C.
  - Timer 2: the same layout from 0x20.
  - Timer 3: the same layout from 0x80.
- R3: Control bits are:
  - bit 7 enables counting;
  - bit 3 picks `tick_fast` when 1 and `tick_slow` when 0.

  An enabled timer drops its value by one on each tick of the chosen source. Ticks of the other source, and all ticks while disabled, leave the value unchanged. Other control bits read zero.
- R4: With control bit 6 set (periodic), a load value N gives an underflow every N+1 ticks. The tick that passes zero reloads the value from the load register.
- R5: With control bit 6 clear (free-running), the tick that passes zero sets the value to all ones for that timer's width (0xFFFF or 0xFFFFFFFF).
- R6: `irq_o[i]` rises on the clock edge of timer i's underflow and stays high until a write of any data to that timer's clear register. If an underflow and a clear write fall in the same cycle, the interrupt stays high.
- R7: A write to a load register also sets the value register at that same edge. This write takes priority over a tick in the same cycle.
- R8: Value registers are read-only. On the 16-bit timers, bits 31:16 of load and value read zero and ignore written data.
- R9: The 40-bit timestamp counts one per `tick_fast` cycle while bit 8 of offset 0x64 is set. It holds while that bit is clear, and it never drives an interrupt.
- R10: A read of offset 0x60 returns timestamp bits 31:0 and captures bits 39:32. Offset 0x64 reads the captured byte in bits 7:0 and the enable in bit 8. All other bits at 0x64 read zero.
- R11: Reads of unmapped or misaligned offsets return zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_rd | input | 1 | Read strobe (only needed for the timestamp capture) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| tick_fast | input | 1 | One-cycle enable of the fast reference tick |
| tick_slow | input | 1 | One-cycle enable of the slow reference tick |
| irq_o | output | 3 | Interrupt per interval timer, bit 0 for timer 1 |

## Verification
The hardest case is an underflow that lands in the same cycle as a clear write to the same timer. The stimulus gets there by loading timer 2 with zero in periodic mode, so that every selected tick is an underflow. It then issues the clear write together with a fast tick.

Free-running wrap on the 32-bit timer would take billions of ticks from a large value. The bench reaches it by loading 1 and giving two ticks. A pseudo-random phase then mixes loads, control changes, clears and ticks of both sources against a behavioural model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH = 3;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_LOAD = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_VAL  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h0C;
  localparam logic [ADDR_W-1:0] STAMP_LO_ADDR = 8'h60;
  localparam logic [ADDR_W-1:0] STAMP_HI_ADDR = 8'h64;

  localparam int CTL_EN_BIT   = 7;
  localparam int CTL_PER_BIT  = 6;
  localparam int CTL_FAST_BIT = 3;
  localparam int STAMP_EN_BIT = 8;

  function automatic logic [ADDR_W-1:0] chan_base(input int idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h20;
      default: return 8'h80;
    endcase
  endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_fast,
  input  logic         tick_slow,
  input  logic         wr_load,
  input  logic [W-1:0] load_data,
  input  logic         wr_ctrl,
  input  logic         cfg_en,
  input  logic         cfg_per,
  input  logic         cfg_fast,
  input  logic         wr_clr,
  output logic [W-1:0] load_o,
  output logic [W-1:0] val_o,
  output logic         en_o,
  output logic         per_o,
  output logic         fast_o,
  output logic         irq_o
);
  logic [W-1:0] load_q, val_q;
  logic en_q, per_q, fast_q, irq_q;
  logic tick_sel, step, underflow;

  assign tick_sel  = fast_q ? tick_fast : tick_slow;
  assign step      = en_q && tick_sel && !wr_load;
  assign underflow = step && (val_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      val_q  <= '0;
    end else if (wr_load) begin
      load_q <= load_data;
      val_q  <= load_data;
    end else if (step) begin
      if (val_q == '0) val_q <= per_q ? load_q : '1;
      else             val_q <= val_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      per_q  <= 1'b0;
      fast_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q   <= cfg_en;
      per_q  <= cfg_per;
      fast_q <= cfg_fast;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (underflow) irq_q <= 1'b1;
    else if (wr_clr)    irq_q <= 1'b0;
  end

  assign load_o = load_q;
  assign val_o  = val_q;
  assign en_o   = en_q;
  assign per_o  = per_q;
  assign fast_o = fast_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/tmr_stamp.sv
module tmr_stamp
  import tmr_pkg::*;
#(
  parameter int STAMP_W = 40,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_cfg,
  input  logic              cfg_en,
  input  logic              rd_low,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o,
  output logic              en_o
);
  localparam int HI_W = STAMP_W - DATA_W;

  logic [STAMP_W-1:0] cnt_q;
  logic [HI_W-1:0]    hi_snap_q;
  logic               en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (en_q && tick) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_snap_q <= '0;
    else if (rd_low) hi_snap_q <= cnt_q[STAMP_W-1:DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (wr_cfg) en_q <= cfg_en;
  end

  always_comb begin
    hi_o = '0;
    hi_o[HI_W-1:0]    = hi_snap_q;
    hi_o[STAMP_EN_BIT] = en_q;
  end

  assign lo_o = cnt_q[DATA_W-1:0];
  assign en_o = en_q;
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import tmr_pkg::*;
#(
  parameter int SHORT_W = 16,
  parameter int LONG_W  = 32,
  parameter int STAMP_W = 40,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic [NUM_CH-1:0] irq_o
);
  logic [DATA_W-1:0] ch_load [NUM_CH];
  logic [DATA_W-1:0] ch_val  [NUM_CH];
  logic              ch_en   [NUM_CH];
  logic              ch_per  [NUM_CH];
  logic              ch_fast [NUM_CH];

  logic [DATA_W-1:0] stamp_lo, stamp_hi;
  logic              stamp_en;

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    localparam int CW = (gi == NUM_CH - 1) ? LONG_W : SHORT_W;
    localparam logic [ADDR_W-1:0] BASE = chan_base(gi);
    logic [CW-1:0] ld_w, val_w;
    logic          wr_ld, wr_ct, wr_cl;

    assign wr_ld = bus_wr && (bus_addr == (BASE | OFS_LOAD));
    assign wr_ct = bus_wr && (bus_addr == (BASE | OFS_CTRL));
    assign wr_cl = bus_wr && (bus_addr == (BASE | OFS_CLR));

    tmr_chan #(.W(CW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_fast(tick_fast),
      .tick_slow(tick_slow),
      .wr_load  (wr_ld),
      .load_data(bus_wdata[CW-1:0]),
      .wr_ctrl  (wr_ct),
      .cfg_en   (bus_wdata[CTL_EN_BIT]),
      .cfg_per  (bus_wdata[CTL_PER_BIT]),
      .cfg_fast (bus_wdata[CTL_FAST_BIT]),
      .wr_clr   (wr_cl),
      .load_o   (ld_w),
      .val_o    (val_w),
      .en_o     (ch_en[gi]),
      .per_o    (ch_per[gi]),
      .fast_o   (ch_fast[gi]),
      .irq_o    (irq_o[gi])
    );

    assign ch_load[gi] = DATA_W'(ld_w);
    assign ch_val[gi]  = DATA_W'(val_w);
  end

  tmr_stamp #(.STAMP_W(STAMP_W), .DATA_W(DATA_W)) u_stamp (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_fast),
    .wr_cfg(bus_wr && (bus_addr == STAMP_HI_ADDR)),
    .cfg_en(bus_wdata[STAMP_EN_BIT]),
    .rd_low(bus_rd && (bus_addr == STAMP_LO_ADDR)),
    .lo_o  (stamp_lo),
    .hi_o  (stamp_hi),
    .en_o  (stamp_en)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == (chan_base(i) | OFS_LOAD)) bus_rdata = ch_load[i];
      if (bus_addr == (chan_base(i) | OFS_VAL))  bus_rdata = ch_val[i];
      if (bus_addr == (chan_base(i) | OFS_CTRL)) begin
        bus_rdata[CTL_EN_BIT]   = ch_en[i];
        bus_rdata[CTL_PER_BIT]  = ch_per[i];
        bus_rdata[CTL_FAST_BIT] = ch_fast[i];
      end
    end
    if (bus_addr == STAMP_LO_ADDR) bus_rdata = stamp_lo;
    if (bus_addr == STAMP_HI_ADDR) bus_rdata = stamp_hi;
  end
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr,
  input logic [7:0]  addr,
  input logic        tf,
  input logic        ts,
  input logic [2:0]  irq,
  input logic [31:0] v0,
  input logic [31:0] v2,
  input logic        en0,
  input logic        en2,
  input logic        per2,
  input logic        fast2,
  input logic        st_en,
  input logic [31:0] st_lo
);
  // R6: an interrupt only rises after its timer sat at zero while enabled
  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[0]) |-> ($past(v0) == 32'd0 && $past(en0)));

  // R6: a clear with no tick of either source drops the interrupt
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 8'h0C && !tf && !ts) |=> !irq[0]);

  // R3: a stopped timer keeps its value unless the load register is written
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en0 && !(wr && addr == 8'h00)) |=> $stable(v0));

  // R5: free-running 32-bit timer wraps to all ones
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en2 && !per2 && v2 == 32'd0 && (fast2 ? tf : ts) && !(wr && addr == 8'h80))
      |=> v2 == 32'hFFFF_FFFF);

  // R9: the timestamp advances by one per fast tick while enabled
  p_stamp_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && tf) |=> st_lo == $past(st_lo) + 32'd1);
endmodule

bind timer_bank timer_bank_chk u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .wr   (bus_wr),
  .addr (bus_addr),
  .tf   (tick_fast),
  .ts   (tick_slow),
  .irq  (irq_o),
  .v0   (ch_val[0]),
  .v2   (ch_val[2]),
  .en0  (ch_en[0]),
  .en2  (ch_en[2]),
  .per2 (ch_per[2]),
  .fast2(ch_fast[2]),
  .st_en(stamp_en),
  .st_lo(stamp_lo)
);

// File: tb/timer_bank_test.sv
module timer_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_fast = 1'b0, tick_slow = 1'b0;
  logic [2:0]  irq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  timer_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_fast(tick_fast), .tick_slow(tick_slow), .irq_o(irq_o)
  );

  // behavioural reference model
  longint mload [3], mval [3], mmask [3];
  int     mctrl [3];
  bit     mirq  [3];
  longint mstamp;
  bit     msen;
  longint mlatch;
  int     mbase [3] = '{32'h00, 32'h20, 32'h80};

  initial begin
    mmask[0] = 64'hFFFF; mmask[1] = 64'hFFFF; mmask[2] = 64'hFFFF_FFFF;
  end

  function automatic longint mread(input int a);
    for (int i = 0; i < 3; i++) begin
      if (a == mbase[i])     return mload[i];
      if (a == mbase[i] + 4) return mval[i];
      if (a == mbase[i] + 8) return longint'(mctrl[i]);
    end
    if (a == 32'h60) return mstamp & 64'hFFFF_FFFF;
    if (a == 32'h64) return (longint'(msen) << 8) | mlatch;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        mload[i] = 0; mval[i] = 0; mctrl[i] = 0; mirq[i] = 0;
      end
      mstamp = 0; msen = 0; mlatch = 0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        bit tk, und;
        tk  = mctrl[i][3] ? tick_fast : tick_slow;
        und = 0;
        if (bus_wr && bus_addr == mbase[i]) begin
          mload[i] = longint'(bus_wdata) & mmask[i];
          mval[i]  = mload[i];
        end else if (mctrl[i][7] && tk) begin
          if (mval[i] == 0) begin
            und = 1;
            mval[i] = mctrl[i][6] ? mload[i] : mmask[i];
          end else mval[i] = mval[i] - 1;
        end
        if (bus_wr && bus_addr == mbase[i] + 8) mctrl[i] = int'(bus_wdata) & 32'hC8;
        if (und) mirq[i] = 1;
        else if (bus_wr && bus_addr == mbase[i] + 12) mirq[i] = 0;
      end
      if (bus_rd && bus_addr == 8'h60) mlatch = (mstamp >> 32) & 64'hFF;
      if (msen && tick_fast) mstamp = (mstamp + 1) & 64'hFF_FFFF_FFFF;
      if (bus_wr && bus_addr == 8'h64) msen = bus_wdata[8];
    end
  end

  task automatic chk(input longint act, input longint exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every clock: interrupt lines against the model (R6)
  always @(negedge clk) begin
    if (rst_n && !done)
      for (int i = 0; i < 3; i++) chk(longint'(irq_o[i]), longint'(mirq[i]), "R6 irq per clock");
  end

  task automatic step(input bit w, input bit r, input logic [7:0] a,
                      input logic [31:0] d, input bit f, input bit s);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    tick_fast = f; tick_slow = s;
    #1;
    if (r) chk(longint'(bus_rdata), mread(int'(a)), "R2 model read");
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; tick_fast = 0; tick_slow = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1, 0, a, d, 0, 0);
  endtask

  task automatic tickf(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 8'h00, 0, 1, 0);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 8'h00, 0, 0, 1);
  endtask

  task automatic rd_exp(input logic [7:0] a, input longint exp, input string tag);
    bus_rd = 1; bus_addr = a;
    #1;
    chk(longint'(bus_rdata), exp, tag);
    chk(longint'(bus_rdata), mread(int'(a)), tag);
    @(negedge clk);
    bus_rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_exp(8'h00, 0, "R1 load");
    rd_exp(8'h04, 0, "R1 value");
    rd_exp(8'h88, 0, "R1 ctrl");
    rd_exp(8'h60, 0, "R1 stamp lo");
    rd_exp(8'h64, 0, "R1 stamp hi");
    chk(longint'(irq_o), 0, "R1 irq");

    // R2 R4 periodic timer 1, fast source
    wr(8'h00, 3);
    wr(8'h08, 32'hC8);
    rd_exp(8'h00, 3, "R2 load offset");
    rd_exp(8'h08, 32'hC8, "R3 ctrl readback");
    tickf(3);
    rd_exp(8'h04, 0, "R4 count reaches zero");
    chk(longint'(irq_o[0]), 0, "R4 no irq before underflow");
    tickf(1);
    rd_exp(8'h04, 3, "R4 reload after N+1 ticks");
    chk(longint'(irq_o[0]), 1, "R6 irq on underflow");
    wr(8'h0C, 32'h5A);
    chk(longint'(irq_o[0]), 0, "R6 clear by any value");

    // R3 source selection and enable
    ticks(1);
    rd_exp(8'h04, 3, "R3 slow tick ignored on fast source");
    wr(8'h08, 32'hC0);
    tickf(1);
    rd_exp(8'h04, 3, "R3 fast tick ignored on slow source");
    ticks(1);
    rd_exp(8'h04, 2, "R3 slow tick counts");
    wr(8'h08, 0);
    tickf(2); ticks(2);
    rd_exp(8'h04, 2, "R3 disabled holds");

    // R7 R8 load behaviour and width
    wr(8'h00, 32'hABCD_1234);
    rd_exp(8'h00, 32'h1234, "R8 upper bits dropped");
    rd_exp(8'h04, 32'h1234, "R7 load copies value");
    wr(8'h04, 32'h55);
    rd_exp(8'h04, 32'h1234, "R8 value read-only");
    wr(8'h08, 32'hFFFF_FFFF);
    rd_exp(8'h08, 32'hC8, "R3 unused ctrl bits zero");
    step(1, 0, 8'h00, 7, 1, 0);
    rd_exp(8'h04, 7, "R7 load beats tick");

    // R5 free-running wrap, 32-bit and 16-bit
    wr(8'h80, 1);
    wr(8'h88, 32'h80);
    ticks(1);
    rd_exp(8'h84, 0, "R5 timer3 at zero");
    ticks(1);
    rd_exp(8'h84, 32'hFFFF_FFFF, "R5 timer3 wraps to all ones");
    chk(longint'(irq_o[2]), 1, "R6 timer3 irq");
    wr(8'h20, 0);
    wr(8'h28, 32'h88);
    tickf(1);
    rd_exp(8'h24, 32'hFFFF, "R5 timer2 wraps to 16-bit all ones");

    // R6 underflow and clear in the same cycle
    wr(8'h20, 0);
    wr(8'h28, 32'hC8);
    wr(8'h2C, 0);
    chk(longint'(irq_o[1]), 0, "R6 timer2 cleared");
    step(1, 0, 8'h2C, 0, 1, 0);
    chk(longint'(irq_o[1]), 1, "R6 underflow wins over clear");

    // R9 R10 timestamp
    rd_exp(8'h60, 0, "R9 stamp disabled holds");
    wr(8'h64, 32'h100);
    tickf(5);
    rd_exp(8'h60, 5, "R9 stamp counts fast ticks");
    rd_exp(8'h64, 32'h100, "R10 high word enable and snapshot");
    ticks(3);
    rd_exp(8'h60, 5, "R9 slow ticks ignored");
    wr(8'h64, 32'hFFFF_FEFF);
    tickf(2);
    rd_exp(8'h60, 5, "R9 stamp stopped");
    rd_exp(8'h64, 0, "R10 only bit 8 stored");

    // R11 unmapped offsets
    wr(8'h40, 32'hFFFF);
    wr(8'h02, 32'hFFFF);
    rd_exp(8'h40, 0, "R11 unmapped read");
    rd_exp(8'h10, 0, "R11 gap read");
    rd_exp(8'h02, 0, "R11 misaligned read");
    rd_exp(8'h00, 7, "R11 load unaffected");

    // mixed phase against the model (R4 R5 R6 R7)
    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      int ch;
      logic [7:0] ra;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ch = int'(lf[7:6]) % 3;
      ra = 8'(mbase[ch] + 4 * int'(lf[9:8]));
      case (lf[5:3])
        3'd0: step(1, 0, 8'(mbase[ch]), {28'd0, lf[13:10]}, lf[0], lf[1]);
        3'd1: step(1, 0, 8'(mbase[ch] + 8), {24'd0, lf[15:8]}, lf[0], lf[1]);
        3'd2: step(1, 0, 8'(mbase[ch] + 12), 32'd0, lf[0], lf[1]);
        3'd3: step(1, 0, 8'h64, {23'd0, lf[2], 8'd0}, lf[0], lf[1]);
        3'd4: step(0, 1, 8'h60, 0, lf[0], lf[1]);
        default: step(0, 1, ra, 0, lf[0], lf[1]);
      endcase
    end
    rd_exp(8'h64, mread(32'h64), "R10 final high word");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule